// File: doc/BRIEF.md
# Circular Read Buffer Event Tracker

This block follows the address stream of serial-flash read commands served from a 2048-byte circular buffer in on-chip SRAM. The buffer is treated as two 1024-byte halves. While the remote host reads bytes at incrementing addresses, the block raises two sticky interrupt status bits. A flip event is raised when the read position leaves one half for the other. A watermark event is raised when the position inside a half reaches a programmed threshold. Software reacts to these events by refilling the half the host has already consumed, while the host reads the other half.

The block also drives the SRAM byte offset of the byte being read. When a command ends, it records the address where that command stopped, so that the next command can continue from it. Serial shifting, opcode decoding and the SRAM itself sit outside the block.

Top module: `rdbuf_tracker`

## Requirements
- R1: After a synchronous active-low reset, both status bits are 0, the last-address output is 0 and the SRAM offset is 0.
- R2: The SRAM offset equals the current read address modulo 2048. A command-start strobe loads the current address from the start-address input. Each accepted byte strobe advances the address by one. If a start strobe and a byte strobe arrive in the same cycle, the start wins and that byte strobe is ignored.
- R3: The flip bit (status bit 0) is set when a byte is read at offset 1023 inside its half, so the next address lies in the other half. This includes the wrap from buffer offset 2047 to 0. It is set once per crossing: reading more bytes inside the new half does not set it again after software clears it.
- R4: The watermark bit (status bit 1) is set when a byte is read at in-half offset `threshold-1`, so the position inside the half reaches the 10-bit threshold. This happens once per half.
- R5: A threshold of 0 disables the watermark event.
- R6: Status bits are sticky. Writing with the clear strobe high clears each bit whose clear-data bit is 1 (bit 0 = flip, bit 1 = watermark). Bits written 0 are unaffected.
- R7: Flip and watermark are independent and may both be pending at the same time.
- R8: If an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: After a command ends, the last-address output holds the command's start address plus the number of bytes read, modulo 2^32. It changes on the 3rd rising edge, counting the edge that samples the command-end strobe as the first. It stays stable until the next command end propagates. Byte strobes must precede the end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start_i | input | 1 | Read command begins; loads the start address |
| cmd_addr_i | input | 32 | Start address of the read command |
| byte_rd_i | input | 1 | One byte is read at the current address |
| cmd_end_i | input | 1 | Read command has finished |
| thresh_i | input | 10 | Watermark threshold inside a half; 0 disables |
| clr_we_i | input | 1 | Status clear write strobe |
| clr_data_i | input | 2 | Write-1-to-clear mask: bit 0 flip, bit 1 watermark |
| sram_off_o | output | 11 | Byte offset of the current address in the buffer |
| last_addr_o | output | 32 | Address where the last finished command stopped |
| irq_flip_o | output | 1 | Sticky flip status |
| irq_wmark_o | output | 1 | Sticky watermark status |

## Verification
Two kinds of collision can fall in the same cycle. The first is a software clear of a status bit together with a byte read that sets that same bit. The bench provokes it by holding the clear strobe for the watermark bit during the exact byte strobe that reads in-half offset `threshold-1`, while that bit is already pending. The bit must still read 1 afterwards, and a later clear on its own must drop it. The second collision is a command start together with a byte strobe: the offset must show the new start address, not that address plus one.

// File: rtl/rdbuf_pkg.sv
// Shared constants for the circular read buffer event tracker.
// Assumes: status vector bit positions are fixed and decoded by software.
package rdbuf_pkg;
    localparam int IRQ_FLIP  = 0;
    localparam int IRQ_WMARK = 1;
    localparam int IRQ_N     = 2;
endpackage

// File: rtl/rdbuf_addr_ctr.sv
// Tracks the current read address, the command start address and the
// number of bytes read in the running command.
// Assumes: a start strobe takes precedence over a byte strobe in the same cycle.
module rdbuf_addr_ctr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_rd,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] byte_cnt
);
    // A byte strobe is accepted only when no command starts in that cycle.
    assign rd_fire = byte_rd && !cmd_start;

    // Load on command start, advance on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            start_addr <= '0;
            byte_cnt   <= '0;
        end else if (cmd_start) begin
            cur_addr   <= cmd_addr;
            start_addr <= cmd_addr;
            byte_cnt   <= '0;
        end else if (byte_rd) begin
            cur_addr   <= cur_addr + 1'b1;
            byte_cnt   <= byte_cnt + 1'b1;
        end
    end

    // R2: an accepted byte moves the address forward by exactly one.
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> cur_addr == $past(cur_addr) + 1'b1);

    // R9: the running address always equals start plus bytes read.
    a_r9_addr_sum: assert property (@(posedge clk) disable iff (!rst_n)
        cur_addr == start_addr + byte_cnt);

    // R2: a start strobe loads the given address.
    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> cur_addr == $past(cmd_addr));
endmodule

// File: rtl/rdbuf_event_det.sv
// Detects flip and watermark events from the offset of the byte being read.
// Assumes: threshold width equals the in-half offset width; threshold 0 disables.
module rdbuf_event_det #(
    parameter int OFF_W = 11,
    localparam int HALF_W = OFF_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic [HALF_W-1:0] thresh,
    output logic              flip_evt,
    output logic              wmark_evt
);
    logic [HALF_W-1:0] in_half;
    logic [HALF_W:0]   next_pos;

    // Position inside the current half and position after this byte.
    always_comb begin
        in_half  = rd_off[HALF_W-1:0];
        next_pos = {1'b0, in_half} + 1'b1;
    end

    // Flip: the last byte of a half is read.
    assign flip_evt  = rd_fire && (&in_half);
    // Watermark: the position after the read reaches a nonzero threshold.
    assign wmark_evt = rd_fire && (thresh != '0) && (next_pos == {1'b0, thresh});

    // R3: two successive byte reads can never both cross a half boundary.
    a_r3_flip_once: assert property (@(posedge clk) disable iff (!rst_n)
        flip_evt |=> !flip_evt);

    // R4: consecutive bytes cannot both hit the same threshold.
    a_r4_wmark_once: assert property (@(posedge clk) disable iff (!rst_n)
        (wmark_evt && $stable(thresh)) |=> !(wmark_evt && $stable(thresh)));
endmodule

// File: rtl/rdbuf_irq_status.sv
// Sticky write-1-to-clear status bits, one per event source.
// Assumes: a set in the same cycle as a clear leaves the bit set.
module rdbuf_irq_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic clr_hit;
        assign clr_hit = clr_we && clr_data[i];

        // Hold each bit until cleared; a new event overrides a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          status[i] <= 1'b0;
            else if (set_evt[i]) status[i] <= 1'b1;
            else if (clr_hit)    status[i] <= 1'b0;
        end

        // R8: an event always leaves its bit set on the next cycle.
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> status[i]);
        // R6: a pending bit without a clear stays pending.
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr_hit) |=> status[i]);
        // R6: a clear with no event drops the bit.
        a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && !set_evt[i]) |=> !status[i]);
    end
endmodule

// File: rtl/rdbuf_last_addr.sv
// Delays the end-of-command address by a fixed number of cycles and holds it.
// Assumes: the address sum presented with the end strobe is final.
module rdbuf_last_addr #(
    parameter int ADDR_W   = 32,
    parameter int LAST_DLY = 3,
    localparam int NST     = (LAST_DLY > 1) ? LAST_DLY - 1 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_end,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [ADDR_W-1:0] last_addr
);
    logic              ld_vld;
    logic [ADDR_W-1:0] ld_dat;

    if (LAST_DLY > 1) begin : g_pipe
        logic              vld [NST];
        logic [ADDR_W-1:0] dat [NST];

        // Shift the end strobe and its address through the delay stages.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < NST; k++) begin
                    vld[k] <= 1'b0;
                    dat[k] <= '0;
                end
            end else begin
                vld[0] <= cmd_end;
                dat[0] <= end_addr;
                for (int k = 1; k < NST; k++) begin
                    vld[k] <= vld[k-1];
                    dat[k] <= dat[k-1];
                end
            end
        end
        assign ld_vld = vld[NST-1];
        assign ld_dat = dat[NST-1];
    end else begin : g_direct
        assign ld_vld = cmd_end;
        assign ld_dat = end_addr;
    end

    // Capture the delayed address into the visible register.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_addr <= '0;
        else if (ld_vld) last_addr <= ld_dat;
    end

    // R9: the register only moves when a delayed end arrives.
    a_r9_last_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_vld |=> $stable(last_addr));
endmodule

// File: rtl/rdbuf_tracker.sv
// Top of the circular read buffer event tracker: address tracking, event
// detection, sticky status and last-address recording.
// Assumes: reads use incrementing addresses and a 2048-byte buffer in two halves.
module rdbuf_tracker #(
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 2048,
    parameter int LAST_DLY  = 3,
    localparam int OFF_W    = $clog2(BUF_BYTES),
    localparam int THR_W    = OFF_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              byte_rd_i,
    input  logic              cmd_end_i,
    input  logic [THR_W-1:0]  thresh_i,
    input  logic              clr_we_i,
    input  logic [1:0]        clr_data_i,
    output logic [OFF_W-1:0]  sram_off_o,
    output logic [ADDR_W-1:0] last_addr_o,
    output logic              irq_flip_o,
    output logic              irq_wmark_o
);
    import rdbuf_pkg::*;

    logic              rd_fire;
    logic [ADDR_W-1:0] cur_addr, start_addr, byte_cnt, end_addr;
    logic              flip_evt, wmark_evt;
    logic [IRQ_N-1:0]  set_vec, status;

    rdbuf_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start_i), .cmd_addr(cmd_addr_i),
        .byte_rd(byte_rd_i), .rd_fire(rd_fire), .cur_addr(cur_addr),
        .start_addr(start_addr), .byte_cnt(byte_cnt)
    );

    // Buffer offset is the address modulo the buffer size.
    assign sram_off_o = cur_addr[OFF_W-1:0];
    // Stop address of the running command.
    assign end_addr   = start_addr + byte_cnt;

    rdbuf_event_det #(.OFF_W(OFF_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_off(cur_addr[OFF_W-1:0]),
        .thresh(thresh_i), .flip_evt(flip_evt), .wmark_evt(wmark_evt)
    );

    // Map event pulses onto their status bit positions.
    always_comb begin
        set_vec            = '0;
        set_vec[IRQ_FLIP]  = flip_evt;
        set_vec[IRQ_WMARK] = wmark_evt;
    end

    rdbuf_irq_status #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_evt(set_vec), .clr_we(clr_we_i),
        .clr_data(clr_data_i), .status(status)
    );

    assign irq_flip_o  = status[IRQ_FLIP];
    assign irq_wmark_o = status[IRQ_WMARK];

    rdbuf_last_addr #(.ADDR_W(ADDR_W), .LAST_DLY(LAST_DLY)) u_last (
        .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end_i), .end_addr(end_addr),
        .last_addr(last_addr_o)
    );

    // R5: with a zero threshold the watermark bit never rises.
    a_r5_thr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh_i == '0 && !irq_wmark_o) |=> !irq_wmark_o);
endmodule

// File: tb/rdbuf_tracker_tb.sv
`timescale 1ns/1ps
module rdbuf_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start_i = 1'b0;
    logic [31:0] cmd_addr_i = '0;
    logic        byte_rd_i = 1'b0;
    logic        cmd_end_i = 1'b0;
    logic [9:0]  thresh_i = '0;
    logic        clr_we_i = 1'b0;
    logic [1:0]  clr_data_i = '0;
    logic [10:0] sram_off_o;
    logic [31:0] last_addr_o;
    logic        irq_flip_o, irq_wmark_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rdbuf_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .cmd_addr_i(cmd_addr_i),
        .byte_rd_i(byte_rd_i), .cmd_end_i(cmd_end_i), .thresh_i(thresh_i),
        .clr_we_i(clr_we_i), .clr_data_i(clr_data_i), .sram_off_o(sram_off_o),
        .last_addr_o(last_addr_o), .irq_flip_o(irq_flip_o), .irq_wmark_o(irq_wmark_o)
    );

    // Vector table: start, byte count, threshold, expected flip, watermark, last address.
    localparam int NV = 8;
    localparam logic [31:0] V_START [NV] = '{32'h0000_0000, 32'h0000_000A, 32'h0000_0400,
        32'h0000_0464, 32'h0000_0800, 32'h1000_07F0, 32'hFFFF_FFFE, 32'h0000_0123};
    localparam int          V_N     [NV] = '{10, 1014, 100, 924, 1024, 32, 4, 0};
    localparam logic [9:0]  V_THR   [NV] = '{10'd0, 10'd0, 10'd50, 10'd50, 10'd1023,
        10'd5, 10'd1, 10'd1};
    localparam logic        V_FLIP  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic        V_WM    [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic [31:0] V_LAST  [NV] = '{32'h0000_000A, 32'h0000_0400, 32'h0000_0464,
        32'h0000_0800, 32'h0000_0C00, 32'h1000_0810, 32'h0000_0002, 32'h0000_0123};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_irq(input logic [1:0] mask);
        @(negedge clk); clr_we_i = 1'b1; clr_data_i = mask;
        @(negedge clk); clr_we_i = 1'b0; clr_data_i = '0;
    endtask

    task automatic start_cmd(input logic [31:0] a);
        @(negedge clk); cmd_start_i = 1'b1; cmd_addr_i = a;
        @(negedge clk); cmd_start_i = 1'b0;
    endtask

    task automatic read_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_rd_i = 1'b1;
        end
        @(negedge clk); byte_rd_i = 1'b0;
    endtask

    task automatic end_cmd();
        @(negedge clk); cmd_end_i = 1'b1;
        @(negedge clk); cmd_end_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk("R1 flip", {31'b0, irq_flip_o}, 32'h0);
        chk("R1 wmark", {31'b0, irq_wmark_o}, 32'h0);
        chk("R1 last", last_addr_o, 32'h0);
        chk("R1 off", {21'b0, sram_off_o}, 32'h0);

        // R2 R3 R4 R5 R7 R9: table walk.
        for (int v = 0; v < NV; v++) begin
            clear_irq(2'b11);
            thresh_i = V_THR[v];
            start_cmd(V_START[v]);
            chk("R2 start offset", {21'b0, sram_off_o}, {21'b0, V_START[v][10:0]});
            read_bytes(V_N[v]);
            end_cmd();
            repeat (4) @(negedge clk);
            chk("R3 flip", {31'b0, irq_flip_o}, {31'b0, V_FLIP[v]});
            chk("R4 R5 wmark", {31'b0, irq_wmark_o}, {31'b0, V_WM[v]});
            chk("R9 last", last_addr_o, V_LAST[v]);
            chk("R2 offset", {21'b0, sram_off_o}, {21'b0, V_LAST[v][10:0]});
        end

        // R7 R6: both pending; a zero mask clears nothing, then clear only flip.
        clear_irq(2'b11);
        thresh_i = 10'd2;
        start_cmd(32'h0000_03FE);
        read_bytes(4);
        chk("R7 both flip", {31'b0, irq_flip_o}, 32'h1);
        chk("R7 both wmark", {31'b0, irq_wmark_o}, 32'h1);
        clear_irq(2'b00);
        chk("R6 zero mask flip", {31'b0, irq_flip_o}, 32'h1);
        chk("R6 zero mask wmark", {31'b0, irq_wmark_o}, 32'h1);
        clear_irq(2'b01);
        chk("R6 clear flip", {31'b0, irq_flip_o}, 32'h0);
        chk("R6 keep wmark", {31'b0, irq_wmark_o}, 32'h1);

        // R3: more reads inside the new half do not set flip again.
        read_bytes(5);
        chk("R3 once per crossing", {31'b0, irq_flip_o}, 32'h0);
        end_cmd();

        // R8: clear of watermark in the same cycle as its event leaves it set.
        thresh_i = 10'd3;
        start_cmd(32'h0000_0400);
        @(negedge clk); byte_rd_i = 1'b1;
        @(negedge clk);
        @(negedge clk); clr_we_i = 1'b1; clr_data_i = 2'b10;
        @(negedge clk); byte_rd_i = 1'b0; clr_we_i = 1'b0; clr_data_i = '0;
        chk("R8 set wins", {31'b0, irq_wmark_o}, 32'h1);
        clear_irq(2'b10);
        chk("R8 later clear", {31'b0, irq_wmark_o}, 32'h0);
        end_cmd();

        // R2: start and byte strobe together; the byte is ignored.
        @(negedge clk); cmd_start_i = 1'b1; cmd_addr_i = 32'h0000_0100; byte_rd_i = 1'b1;
        @(negedge clk); cmd_start_i = 1'b0; byte_rd_i = 1'b0;
        chk("R2 start wins", {21'b0, sram_off_o}, 32'h100);

        // R9: update lands on the third edge after the end strobe is sampled.
        read_bytes(7);
        prev = last_addr_o;
        @(negedge clk); cmd_end_i = 1'b1;
        @(negedge clk); cmd_end_i = 1'b0;
        @(negedge clk);
        chk("R9 before third edge", last_addr_o, prev);
        @(negedge clk);
        chk("R9 at third edge", last_addr_o, 32'h0000_0107);
        repeat (5) @(negedge clk);
        chk("R9 stable", last_addr_o, 32'h0000_0107);

        // R1: reset again clears status.
        thresh_i = 10'd1;
        start_cmd(32'h0);
        read_bytes(1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset wmark", {31'b0, irq_wmark_o}, 32'h0);
        chk("R1 reset last", last_addr_o, 32'h0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule